// File: doc/BRIEF.md
# Two-Channel DMA Interrupt Aggregator

This block merges the interrupt sources of a two-channel DMA engine into a single level-sensitive interrupt request. Each channel raises two kinds of events: an end-of-process pulse when a buffer transfer completes, and a reload pulse when the channel runs in chaining mode and needs a fresh set of addresses and a count. The block latches these events in a read-only status register. A read/write enable register decides which completion events are latched at all.

While a channel is in chaining mode, only its reload flag can raise the request. Outside chaining mode, only its completion flag can. Software clears a completion flag by clearing that channel's bit in the main DMA status register, which reaches this block as a strobe. A reload flag is cleared as a side effect of writing the top byte of that channel's target address, which also arrives as a strobe. Registers are reached over a plain byte-wide bus with an address, a write strobe and combinational read data. There is no flow control on this bus, so it has no valid/ready handshake.

Top module: `dma_irq_agg`

## Requirements
- R1: The enable register sits at offset 0. Bit c (c = 0, 1) is read/write and enables completion latching for channel c. Bits 7..2 read as zero whatever was written. The register resets to 0.
- R2: A channel's completion status bit is set by its end-of-process pulse only when that channel's enable bit is 1. With the enable bit at 0, the pulse leaves the status bit unchanged.
- R3: A channel's completion status bit clears one clock after that channel's main-status clear strobe.
- R4: A channel's reload status bit is set by its reload pulse and clears one clock after that channel's target-address top-byte write strobe.
- R5: The status register sits at offset 1. Bit 0 is channel 0 completion, bit 1 is channel 1 completion, bit 4 is channel 0 reload and bit 5 is channel 1 reload. All other bits read 0, and every status bit resets to 0.
- R6: The request output is registered. It equals the OR over the channels of each channel's active source, and it follows a status change one clock later.
- R7: For a channel in chaining mode, only its reload bit is an active source. Otherwise, only its completion bit is an active source.
- R8: When a set event and a clear event reach the same status bit in the same cycle, the bit ends up set.
- R9: Writes to offset 1 change no status bit. Changing an enable bit neither sets nor clears a status bit that is already latched.
- R10: Offsets 2 and 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_eop | input | NUM_CH | Per-channel end-of-process pulse |
| ch_chain_req | input | NUM_CH | Per-channel reload-needed pulse |
| ch_chain_mode | input | NUM_CH | Per-channel chaining mode level |
| ch_tgt_msb_wr | input | NUM_CH | Per-channel strobe: top byte of target address written |
| ch_done_clr | input | NUM_CH | Per-channel strobe: completion bit cleared in main DMA status |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the offset on bus_addr (combinational) |
| irq | output | 1 | Registered interrupt request level |

## Verification
The bench builds the block with the default values NUM_CH = 2, ADDR_W = 2 and DATA_W = 8. With these values both channels, all four status positions (bits 0, 1, 4 and 5) and the two unmapped offsets 2 and 3 can be exercised. A vector table walks both channels through completion, clearing, reload, mode switches, enable changes, status writes and same-cycle set/clear collisions. Directed tests then cover the reset values, the read-as-zero behaviour of reserved and unmapped bits, and the one-clock delay of the request.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_EN   = 0;
  localparam int REG_STAT = 1;
endpackage

// File: rtl/dma_irq_en_reg.sv
module dma_irq_en_reg #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_stb) en_q <= wdata;
  end
endmodule

// File: rtl/dma_irq_chan_stat.sv
module dma_irq_chan_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic eop,
  input  logic en,
  input  logic done_clr,
  input  logic chain_req,
  input  logic tgt_msb_wr,
  output logic done_q,
  output logic chain_q
);
  logic done_set;
  assign done_set = eop & en;

  // Set has priority over clear so that no event is dropped.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      chain_q <= 1'b0;
    end else begin
      if (done_set)      done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      if (chain_req)       chain_q <= 1'b1;
      else if (tgt_msb_wr) chain_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_irq_req_merge.sv
module dma_irq_req_merge #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] done,
  input  logic [NUM_CH-1:0] chain,
  input  logic [NUM_CH-1:0] mode,
  output logic              irq
);
  logic [NUM_CH-1:0] active;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_src
    assign active[c] = mode[c] ? chain[c] : done[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |active;
  end
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_eop,
  input  logic [NUM_CH-1:0] ch_chain_req,
  input  logic [NUM_CH-1:0] ch_chain_mode,
  input  logic [NUM_CH-1:0] ch_tgt_msb_wr,
  input  logic [NUM_CH-1:0] ch_done_clr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import dma_irq_pkg::*;

  localparam int CHAIN_BASE = DATA_W / 2;

  logic              sel_en;
  logic              sel_stat;
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] done_q;
  logic [NUM_CH-1:0] chain_q;

  assign sel_en   = (bus_addr == ADDR_W'(REG_EN));
  assign sel_stat = (bus_addr == ADDR_W'(REG_STAT));

  dma_irq_en_reg #(.NUM_CH(NUM_CH)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (bus_wr & sel_en),
    .wdata  (bus_wdata[NUM_CH-1:0]),
    .en_q   (en_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_irq_chan_stat u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .eop        (ch_eop[c]),
      .en         (en_q[c]),
      .done_clr   (ch_done_clr[c]),
      .chain_req  (ch_chain_req[c]),
      .tgt_msb_wr (ch_tgt_msb_wr[c]),
      .done_q     (done_q[c]),
      .chain_q    (chain_q[c])
    );
  end

  dma_irq_req_merge #(.NUM_CH(NUM_CH)) u_merge (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (done_q),
    .chain (chain_q),
    .mode  (ch_chain_mode),
    .irq   (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_en) begin
      bus_rdata[NUM_CH-1:0] = en_q;
    end else if (sel_stat) begin
      for (int c = 0; c < NUM_CH; c++) begin
        bus_rdata[c]              = done_q[c];
        bus_rdata[CHAIN_BASE + c] = chain_q[c];
      end
    end
  end
endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_eop,
  input logic [NUM_CH-1:0] ch_chain_req,
  input logic [NUM_CH-1:0] ch_chain_mode,
  input logic [NUM_CH-1:0] ch_tgt_msb_wr,
  input logic [NUM_CH-1:0] ch_done_clr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] done_q,
  input logic [NUM_CH-1:0] chain_q,
  input logic              irq
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    a_r2_eop_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_eop[c] && en_q[c]) |=> done_q[c]);
    a_r2_eop_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_eop[c] && !en_q[c] && !done_q[c]) |=> !done_q[c]);
    a_r3_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_done_clr[c] && !ch_eop[c]) |=> !done_q[c]);
    a_r4_chain_set: assert property (@(posedge clk) disable iff (!rst_n)
      ch_chain_req[c] |=> chain_q[c]);
    a_r4_chain_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_tgt_msb_wr[c] && !ch_chain_req[c]) |=> !chain_q[c]);
    a_r9_stat_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(1) && !ch_eop[c] && !ch_done_clr[c]
       && !ch_chain_req[c] && !ch_tgt_msb_wr[c])
      |=> ($stable(done_q[c]) && $stable(chain_q[c])));
  end

  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q == '0 && chain_q == '0) |=> !irq);
  a_r7_chain_source: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_chain_mode & chain_q) != '0) |=> irq);
endmodule

bind dma_irq_agg dma_irq_agg_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ch_eop        (ch_eop),
  .ch_chain_req  (ch_chain_req),
  .ch_chain_mode (ch_chain_mode),
  .ch_tgt_msb_wr (ch_tgt_msb_wr),
  .ch_done_clr   (ch_done_clr),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .en_q          (en_q),
  .done_q        (done_q),
  .chain_q       (chain_q),
  .irq           (irq)
);

// File: tb/tb_dma_irq_agg.sv
module tb_dma_irq_agg;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int NVEC   = 22;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_CH-1:0] ch_eop = '0, ch_chain_req = '0, ch_chain_mode = '0;
  logic [NUM_CH-1:0] ch_tgt_msb_wr = '0, ch_done_clr = '0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq;
  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  dma_irq_agg #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .ch_eop(ch_eop), .ch_chain_req(ch_chain_req),
    .ch_chain_mode(ch_chain_mode), .ch_tgt_msb_wr(ch_tgt_msb_wr),
    .ch_done_clr(ch_done_clr), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Fields: mode, eop, chain_req, tgt_wr, done_clr, wr, addr, wdata, exp_status, exp_irq
  localparam logic [29:0] VEC [NVEC] = '{
    {2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 2'd0, 8'h03, 8'h00, 1'b0},
    {2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 2'd1, 8'h00, 8'h01, 1'b1},
    {2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 1'b0, 2'd1, 8'h00, 8'h00, 1'b0},
    {2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 2'd1, 8'h00, 8'h02, 1'b1},
    {2'b00, 2'b01, 2'b00, 2'b00, 2'b10, 1'b0, 2'd1, 8'h00, 8'h01, 1'b1},
    {2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 1'b0, 2'd1, 8'h00, 8'h00, 1'b0},
    {2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 1'b0, 2'd1, 8'h00, 8'h10, 1'b0},
    {2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 2'd1, 8'h00, 8'h10, 1'b1},
    {2'b01, 2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 2'd1, 8'h00, 8'h11, 1'b1},
    {2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 1'b0, 2'd1, 8'h00, 8'h01, 1'b0},
    {2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 2'd1, 8'h00, 8'h01, 1'b1},
    {2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 2'd0, 8'h00, 8'h01, 1'b1},
    {2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 2'd1, 8'h00, 8'h01, 1'b1},
    {2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 1'b0, 2'd1, 8'h00, 8'h00, 1'b0},
    {2'b10, 2'b00, 2'b10, 2'b10, 2'b00, 1'b0, 2'd1, 8'h00, 8'h20, 1'b1},
    {2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 2'd1, 8'hFF, 8'h20, 1'b1},
    {2'b10, 2'b00, 2'b00, 2'b10, 2'b00, 1'b0, 2'd1, 8'h00, 8'h00, 1'b0},
    {2'b11, 2'b00, 2'b11, 2'b00, 2'b00, 1'b0, 2'd1, 8'h00, 8'h30, 1'b1},
    {2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 1'b0, 2'd1, 8'h00, 8'h00, 1'b0},
    {2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 2'd0, 8'h03, 8'h00, 1'b0},
    {2'b00, 2'b01, 2'b00, 2'b00, 2'b01, 1'b0, 2'd1, 8'h00, 8'h01, 1'b1},
    {2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 1'b0, 2'd1, 8'h00, 8'h00, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state (R1, R5)
    bus_addr = 2'd0;
    @(negedge clk);
    chk("R1 enable reset", bus_rdata, 8'h00);
    bus_addr = 2'd1;
    #1;
    chk("R5 status reset", bus_rdata, 8'h00);
    chk("R6 irq reset", {7'b0, irq}, 8'h00);

    // R1 reserved enable bits read zero
    bus_addr = 2'd0; bus_wr = 1'b1; bus_wdata = 8'hFE;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R1 enable readback", bus_rdata, 8'h02);
    // R10 unmapped offsets
    bus_addr = 2'd2; #1;
    chk("R10 offset 2", bus_rdata, 8'h00);
    bus_addr = 2'd3; #1;
    chk("R10 offset 3", bus_rdata, 8'h00);

    // Vector walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      ch_chain_mode = VEC[i][29:28];
      ch_eop        = VEC[i][27:26];
      ch_chain_req  = VEC[i][25:24];
      ch_tgt_msb_wr = VEC[i][23:22];
      ch_done_clr   = VEC[i][21:20];
      bus_wr        = VEC[i][19];
      bus_addr      = VEC[i][18:17];
      bus_wdata     = VEC[i][16:9];
      @(negedge clk);
      ch_eop = '0; ch_chain_req = '0; ch_tgt_msb_wr = '0; ch_done_clr = '0;
      bus_wr = 1'b0; bus_addr = 2'd1; bus_wdata = '0;
      @(negedge clk);
      chk($sformatf("R2 R3 R4 R8 R9 status vec %0d", i), bus_rdata, VEC[i][8:1]);
      chk($sformatf("R6 R7 irq vec %0d", i), {7'b0, irq}, {7'b0, VEC[i][0]});
    end

    // R6: one-clock request latency
    @(negedge clk);
    ch_eop = 2'b10;
    @(negedge clk);
    ch_eop = '0;
    chk("R6 status before irq", bus_rdata, 8'h02);
    chk("R6 irq not yet", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R6 irq one clock later", {7'b0, irq}, 8'h01);
    ch_done_clr = 2'b10;
    @(negedge clk);
    ch_done_clr = '0;
    chk("R3 cleared", bus_rdata, 8'h00);
    @(negedge clk);
    chk("R6 irq drops", {7'b0, irq}, 8'h00);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule